// File: doc/BRIEF.md
# Transmit Test Pattern Generator

This block sits in the transmit path of a serial link PCS and replaces the normal 64-bit data words with a test stream when test mode is on. It has three pattern sources. The first is a square wave with a programmable run length. The second is a bank of four inverted PRBS generators. The third is a 58-bit self-synchronising scrambler, started from one of two programmed seeds and fed with either all-zero data or a pair of local-fault ordered sets. All configuration arrives as static level inputs. The output is one registered data word and a valid strobe per clock.

When test mode is off, the block behaves as a one-cycle register stage for the normal data. Each time test mode turns on, every generator starts from its initial state. The square-wave and pseudo-random sources each have their own advance enable. While the enable for the active source is low, the output word holds and the valid strobe drops.

Top module: `txtest_patgen`

## Requirements
- R1: With `cfg_test_en` = 0, `out_data` and `out_valid` equal `norm_data` and `norm_valid` from the previous clock edge.
- R2: While `rst_n` is low, `out_data` is all zeros and `out_valid` is 0.
- R3: With `cfg_sq_sel` = 1, the output bit stream is N ones followed by N zeros, repeated. Bit 0 of each word comes first in time. The stream starts with a run of ones when test mode turns on. N is the value of `cfg_run_code`, which is sampled while test mode is off.
- R4: A run code outside the set {1, 4, 5, 6, 8, 10} gives a run length of 1.
- R5: With `cfg_sq_sel` = 0, `cfg_prbs_en` bit 0, 1, 2 and 3 selects PRBS with polynomial x^7+x^6+1, x^9+x^5+1, x^23+x^18+1 and x^31+x^28+1 respectively. Each PRBS generator is a shift register s that starts all ones and is never all zeros. Per bit, it computes f = s[order-1] XOR s[tap-1], emits NOT f, and then shifts f into s[0].
- R6: When more than one `cfg_prbs_en` bit is set, the lowest-numbered bit (lowest order) wins.
- R7: With `cfg_sq_sel` = 0 and `cfg_prbs_en` = 0, each output bit is o = d XOR s[38] XOR s[57]. Here d is the payload bit and s is a 58-bit history of past output bits, with o shifted into s[0]. The history starts at `cfg_seed_a`.
- R8: The scrambler history is reloaded at the start of every 128th output block. The reload alternates between seeds: A for blocks 0 to 127, B for blocks 128 to 255, A again for blocks 256 to 383, and so on.
- R9: With `cfg_lf_payload` = 1, the scrambled payload is 64'h0100009C_0100009C (bit 0 first). With `cfg_lf_payload` = 0, the payload is all zeros.
- R10: In test mode, `out_valid` equals the advance enable of the active source from the previous edge: `cfg_sq_clk_en` for the square wave, and `cfg_prbs_clk_en` for both pseudo-random sources. While that enable is 0, `out_data` holds and the source does not advance, so the stream resumes without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_test_en | input | 1 | Test mode on; off means pass-through and restart |
| cfg_sq_sel | input | 1 | 1 = square wave, 0 = pseudo-random |
| cfg_run_code | input | 4 | Square-wave run length |
| cfg_prbs_en | input | 4 | One-hot PRBS polynomial choice |
| cfg_lf_payload | input | 1 | Scrambled payload: 1 = local-fault sets, 0 = zeros |
| cfg_prbs_clk_en | input | 1 | Advance enable for the pseudo-random sources |
| cfg_sq_clk_en | input | 1 | Advance enable for the square wave |
| cfg_seed_a | input | 58 | First scrambler seed |
| cfg_seed_b | input | 58 | Second scrambler seed |
| norm_data | input | 64 | Normal transmit data |
| norm_valid | input | 1 | Normal data valid |
| out_data | output | 64 | Transmit word |
| out_valid | output | 1 | Transmit word valid |

## Verification
The seed-swap assertion assumes that `cfg_seed_a` and `cfg_seed_b` do not change while a scrambled run is in progress. The run-length assertions assume that the run code is changed only while test mode is off. The stimulus respects both assumptions: it reprograms every configuration field only while `cfg_test_en` is low, then holds one idle cycle so the restart loads. The bench then sweeps all sixteen run codes, all fifteen non-zero PRBS enable combinations and both scrambler payloads over more than two seed periods, and works out each expected word bit by bit from the polynomial and run-length definitions.

// File: rtl/txtp_pkg.sv
package txtp_pkg;

   localparam int PRBS_N = 4;
   localparam logic [31:0] LF_OSET = 32'h0100_009C;

   function automatic int prbs_order(input int idx);
      case (idx)
         0:       return 7;
         1:       return 9;
         2:       return 23;
         default: return 31;
      endcase
   endfunction

   function automatic int prbs_tap(input int idx);
      case (idx)
         0:       return 6;
         1:       return 5;
         2:       return 18;
         default: return 28;
      endcase
   endfunction

   function automatic logic run_is_legal(input int n);
      return (n == 1) || (n == 4) || (n == 5) || (n == 6) || (n == 8) || (n == 10);
   endfunction

endpackage

// File: rtl/txtp_square.sv
module txtp_square #(
   parameter int WORD_W = 64,
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              adv,
   input  logic [CODE_W-1:0] code,
   output logic [WORD_W-1:0] word
);
   localparam int PH_W = CODE_W + 1;

   logic [CODE_W-1:0] run_q;
   logic [CODE_W-1:0] run_dec;
   logic [PH_W-1:0]   ph_q;
   logic [PH_W-1:0]   ph_nxt;
   logic [PH_W-1:0]   period;

   generate
      if (CODE_W < 4) begin : g_bad_code
         $error("txtp_square: CODE_W must hold run length 10");
      end
   endgenerate

   assign run_dec = txtp_pkg::run_is_legal(int'(code)) ? code : CODE_W'(1);
   assign period  = {run_q, 1'b0};

   always_comb begin
      logic [PH_W-1:0] q;
      q = ph_q;
      for (int i = 0; i < WORD_W; i++) begin
         word[i] = (q < {1'b0, run_q});
         if (q == period - 1'b1) q = '0;
         else                    q = q + 1'b1;
      end
      ph_nxt = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= CODE_W'(1);
         ph_q  <= '0;
      end else if (restart) begin
         run_q <= run_dec;
         ph_q  <= '0;
      end else if (adv) begin
         ph_q  <= ph_nxt;
      end
   end

   AST_RUN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      txtp_pkg::run_is_legal(int'(run_q))); // R4
   AST_SQ_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q < period); // R3

endmodule

// File: rtl/txtp_prbs.sv
module txtp_prbs #(
   parameter int WORD_W = 64,
   parameter int ORDER  = 7,
   parameter int TAP    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              adv,
   output logic [WORD_W-1:0] word
);
   logic [ORDER-1:0] st_q;
   logic [ORDER-1:0] st_nxt;

   generate
      if (TAP >= ORDER || TAP < 1) begin : g_bad_tap
         $error("txtp_prbs: TAP must lie below ORDER");
      end
   endgenerate

   always_comb begin
      logic [ORDER-1:0] s;
      logic             fb;
      s = st_q;
      for (int i = 0; i < WORD_W; i++) begin
         fb      = s[ORDER-1] ^ s[TAP-1];
         word[i] = ~fb;
         s       = {s[ORDER-2:0], fb};
      end
      st_nxt = (s == '0) ? '1 : s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st_q <= '1;
      else if (restart) st_q <= '1;
      else if (adv)     st_q <= st_nxt;
   end

   AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != '0); // R5

endmodule

// File: rtl/txtp_seeded.sv
module txtp_seeded #(
   parameter int WORD_W = 64,
   parameter int SEED_W = 58,
   parameter int TAP    = 39,
   parameter int BLK    = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              adv,
   input  logic [WORD_W-1:0] payload,
   input  logic [SEED_W-1:0] seed_a,
   input  logic [SEED_W-1:0] seed_b,
   output logic [WORD_W-1:0] word
);
   localparam int CNT_W = (BLK > 1) ? $clog2(BLK) : 1;

   logic [SEED_W-1:0] st_q;
   logic [SEED_W-1:0] st_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              use_b_q;
   logic              wrap;

   generate
      if (TAP >= SEED_W || TAP < 1) begin : g_bad_tap
         $error("txtp_seeded: TAP must lie below SEED_W");
      end
      if (BLK < 2) begin : g_bad_blk
         $error("txtp_seeded: BLK must be at least 2");
      end
   endgenerate

   assign wrap = (cnt_q == CNT_W'(BLK - 1));

   always_comb begin
      logic [SEED_W-1:0] s;
      logic              o;
      s = st_q;
      for (int i = 0; i < WORD_W; i++) begin
         o       = payload[i] ^ s[TAP-1] ^ s[SEED_W-1];
         word[i] = o;
         s       = {s[SEED_W-2:0], o};
      end
      st_nxt = s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= '0;
         cnt_q   <= '0;
         use_b_q <= 1'b0;
      end else if (restart) begin
         st_q    <= seed_a;
         cnt_q   <= '0;
         use_b_q <= 1'b0;
      end else if (adv) begin
         if (wrap) begin
            st_q    <= use_b_q ? seed_a : seed_b;
            use_b_q <= ~use_b_q;
            cnt_q   <= '0;
         end else begin
            st_q    <= st_nxt;
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   AST_SEED_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && adv && wrap) |=> (st_q == $past(use_b_q ? seed_a : seed_b))); // R8

endmodule

// File: rtl/txtest_patgen.sv
module txtest_patgen #(
   parameter int WORD_W   = 64,
   parameter int CODE_W   = 4,
   parameter int SEED_W   = 58,
   parameter int SEED_TAP = 39,
   parameter int SEED_BLK = 128
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_test_en,
   input  logic                          cfg_sq_sel,
   input  logic [CODE_W-1:0]             cfg_run_code,
   input  logic [txtp_pkg::PRBS_N-1:0]   cfg_prbs_en,
   input  logic                          cfg_lf_payload,
   input  logic                          cfg_prbs_clk_en,
   input  logic                          cfg_sq_clk_en,
   input  logic [SEED_W-1:0]             cfg_seed_a,
   input  logic [SEED_W-1:0]             cfg_seed_b,
   input  logic [WORD_W-1:0]             norm_data,
   input  logic                          norm_valid,
   output logic [WORD_W-1:0]             out_data,
   output logic                          out_valid
);
   localparam int NP = txtp_pkg::PRBS_N;

   generate
      if (WORD_W < 32 || (WORD_W % 32) != 0) begin : g_bad_word
         $error("txtest_patgen: WORD_W must be a multiple of 32");
      end
   endgenerate

   logic              restart;
   logic              use_prbs;
   logic              gen_en;
   logic              adv;
   logic [WORD_W-1:0] sq_word;
   logic [WORD_W-1:0] seed_word;
   logic [WORD_W-1:0] prbs_word;
   logic [WORD_W-1:0] pat_word;
   logic [WORD_W-1:0] payload;
   logic [WORD_W-1:0] prbs_bank [NP];

   assign restart  = ~cfg_test_en;
   assign use_prbs = ~cfg_sq_sel & (|cfg_prbs_en);
   assign gen_en   = cfg_sq_sel ? cfg_sq_clk_en : cfg_prbs_clk_en;
   assign adv      = cfg_test_en & gen_en;
   assign payload  = cfg_lf_payload ? {(WORD_W/32){txtp_pkg::LF_OSET}} : '0;

   txtp_square #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_square (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .adv(adv & cfg_sq_sel), .code(cfg_run_code), .word(sq_word)
   );

   for (genvar gi = 0; gi < NP; gi++) begin : g_prbs
      txtp_prbs #(
         .WORD_W(WORD_W),
         .ORDER (txtp_pkg::prbs_order(gi)),
         .TAP   (txtp_pkg::prbs_tap(gi))
      ) u_prbs (
         .clk(clk), .rst_n(rst_n), .restart(restart),
         .adv(adv & use_prbs), .word(prbs_bank[gi])
      );
   end

   txtp_seeded #(.WORD_W(WORD_W), .SEED_W(SEED_W), .TAP(SEED_TAP), .BLK(SEED_BLK)) u_seeded (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .adv(adv & ~cfg_sq_sel & ~use_prbs), .payload(payload),
      .seed_a(cfg_seed_a), .seed_b(cfg_seed_b), .word(seed_word)
   );

   always_comb begin
      prbs_word = '0;
      for (int i = NP - 1; i >= 0; i--) begin
         if (cfg_prbs_en[i]) prbs_word = prbs_bank[i];
      end
   end

   assign pat_word = cfg_sq_sel ? sq_word : (use_prbs ? prbs_word : seed_word);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_valid <= 1'b0;
      end else if (!cfg_test_en) begin
         out_data  <= norm_data;
         out_valid <= norm_valid;
      end else begin
         out_valid <= gen_en;
         if (gen_en) out_data <= pat_word;
      end
   end

   AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_test_en |=> (out_data == $past(norm_data)) && (out_valid == $past(norm_valid))); // R1
   AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_test_en && !gen_en) |=> !out_valid && $stable(out_data)); // R10
   AST_GATE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_test_en && gen_en) |=> out_valid); // R10

endmodule

// File: tb/txtest_patgen_tb.sv
module txtest_patgen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_test_en = 1'b0;
   logic        cfg_sq_sel = 1'b0;
   logic [3:0]  cfg_run_code = 4'd1;
   logic [3:0]  cfg_prbs_en = 4'd0;
   logic        cfg_lf_payload = 1'b0;
   logic        cfg_prbs_clk_en = 1'b0;
   logic        cfg_sq_clk_en = 1'b0;
   logic [57:0] cfg_seed_a = 58'h35A5_C3E7_F012_34;
   logic [57:0] cfg_seed_b = 58'h2C3B_1F00_DEAD_77;
   logic [63:0] norm_data = '0;
   logic        norm_valid = 1'b0;
   logic [63:0] out_data;
   logic        out_valid;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   txtest_patgen u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_test_en(cfg_test_en), .cfg_sq_sel(cfg_sq_sel),
      .cfg_run_code(cfg_run_code), .cfg_prbs_en(cfg_prbs_en), .cfg_lf_payload(cfg_lf_payload),
      .cfg_prbs_clk_en(cfg_prbs_clk_en), .cfg_sq_clk_en(cfg_sq_clk_en),
      .cfg_seed_a(cfg_seed_a), .cfg_seed_b(cfg_seed_b),
      .norm_data(norm_data), .norm_valid(norm_valid),
      .out_data(out_data), .out_valid(out_valid)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] sq_expect(input longint g, input int n);
      logic [63:0] w;
      for (int i = 0; i < 64; i++) w[i] = ((g + i) % (2 * n)) < n;
      return w;
   endfunction

   // restart generators with the current configuration, then enter test mode
   task automatic restart_test();
      cfg_test_en = 1'b0;
      step();
      cfg_test_en = 1'b1;
   endtask

   initial begin
      repeat (3) step();
      // R2: reset state
      chk(out_data == 64'd0, "R2", out_data, 64'd0);
      chk(out_valid == 1'b0, "R2", {63'd0, out_valid}, 64'd0);
      rst_n = 1'b1;
      step();

      // R1: pass-through when test mode is off
      for (int k = 0; k < 8; k++) begin
         logic [63:0] d;
         d = {32'hA5C3_0000 + 32'(k), 32'(k * 32'h1357_9BDF)};
         norm_data  = d;
         norm_valid = k[0];
         step();
         chk(out_data == d, "R1", out_data, d);
         chk(out_valid == k[0], "R1", {63'd0, out_valid}, {63'd0, k[0]});
      end

      // R3/R4/R10: square wave, every run code, with a gating pause
      cfg_sq_sel    = 1'b1;
      cfg_sq_clk_en = 1'b1;
      for (int c = 0; c < 16; c++) begin
         int     n;
         longint g;
         logic [63:0] last;
         n = (c == 1 || c == 4 || c == 5 || c == 6 || c == 8 || c == 10) ? c : 1;
         cfg_run_code = 4'(c);
         restart_test();
         g = 0;
         last = '0;
         for (int w = 0; w < 6; w++) begin
            step();
            last = sq_expect(g, n);
            if (c == n) chk(out_data == last, "R3", out_data, last);
            else        chk(out_data == last, "R4", out_data, last);
            chk(out_valid == 1'b1, "R10", {63'd0, out_valid}, 64'd1);
            g += 64;
            if (w == 2) begin
               cfg_sq_clk_en = 1'b0;
               step();
               chk(out_valid == 1'b0, "R10", {63'd0, out_valid}, 64'd0);
               chk(out_data == last, "R10", out_data, last);
               step();
               chk(out_data == last, "R10", out_data, last);
               cfg_sq_clk_en = 1'b1;
            end
         end
      end

      // R5/R6: PRBS polynomials, every enable combination
      cfg_sq_sel      = 1'b0;
      cfg_prbs_clk_en = 1'b1;
      for (int pe = 1; pe < 16; pe++) begin
         int ord, tp, sel;
         logic [31:0] ps;
         sel = 0;
         for (int b = 3; b >= 0; b--) if (pe[b]) sel = b;
         ord = (sel == 0) ? 7 : (sel == 1) ? 9 : (sel == 2) ? 23 : 31;
         tp  = (sel == 0) ? 6 : (sel == 1) ? 5 : (sel == 2) ? 18 : 28;
         ps  = (32'd1 << ord) - 32'd1;
         cfg_prbs_en = 4'(pe);
         restart_test();
         for (int w = 0; w < 8; w++) begin
            logic [63:0] e;
            for (int i = 0; i < 64; i++) begin
               logic fb;
               fb   = ps[ord-1] ^ ps[tp-1];
               e[i] = ~fb;
               ps   = ((ps << 1) | {31'd0, fb}) & ((32'd1 << ord) - 32'd1);
            end
            step();
            if ($countones(pe) == 1) chk(out_data == e, "R5", out_data, e);
            else                     chk(out_data == e, "R6", out_data, e);
         end
      end

      // R7/R8/R9: seeded scrambler over more than two seed periods
      cfg_prbs_en = 4'd0;
      for (int lf = 0; lf < 2; lf++) begin
         logic [57:0] ss;
         logic [63:0] pay;
         cfg_lf_payload = lf[0];
         pay = lf[0] ? 64'h0100009C_0100009C : 64'd0;
         restart_test();
         ss = cfg_seed_a;
         for (int k = 0; k < 272; k++) begin
            logic [63:0] e;
            if ((k % 128) == 0) ss = (((k / 128) % 2) == 0) ? cfg_seed_a : cfg_seed_b;
            for (int i = 0; i < 64; i++) begin
               logic o;
               o    = pay[i] ^ ss[38] ^ ss[57];
               e[i] = o;
               ss   = {ss[56:0], o};
            end
            step();
            if (k >= 128 && k < 132)  chk(out_data == e, "R8", out_data, e);
            else if (lf == 1)         chk(out_data == e, "R9", out_data, e);
            else                      chk(out_data == e, "R7", out_data, e);
         end
      end

      cfg_test_en = 1'b0;
      step();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule